// File: doc/BRIEF.md
# Bidirectional GPIO port with per-pin peripheral takeover

This block is an 8-pin general-purpose I/O port reached over a simple register bus. Each pin has a stored output value (the data latch) and a stored direction bit. A pin whose direction bit is 1 is an input, and its pad driver is off. A pin whose direction bit is 0 is an output, and the pad drives the data-latch value. The pad is modelled as three separate signals: an output value, an output enable and an input value.

Each pin also has a peripheral-select input. While it is active, an on-chip peripheral owns the pin. The peripheral supplies both the value driven on the pad and the output enable. It can therefore force the pin to be an output or an input whatever the stored direction bit says. The takeover never modifies the stored latches. When the select drops, the pin goes back to its stored configuration on the next clock edge.

Pad inputs pass through a two-flop synchroniser. The synchronised levels feed both the port read path and the peripheral input bus.

Top module: `pin_port_ovr`

## Requirements
- R1: After synchronous reset, the direction register reads 8'hFF, the data latch reads 8'h00, pad_oe is 8'h00, and the pin-read value is 8'h00.
- R2: On a pin whose peripheral select is low, pad_oe is the inverse of the direction bit and pad_out is the data-latch bit. The pad signals follow a change in the latches one clock edge after the latch updates.
- R3: When wr_en is 1 at a rising edge, wr_sel=0 loads wr_data into the data latch and wr_sel=1 loads it into the direction register. When wr_en is 0, neither register changes.
- R4: rd_data is combinational from rd_sel: 0 returns the data latch, 1 returns the direction register, 2 returns the synchronised pin levels, and 3 returns 8'h00.
- R5: On a pin whose peripheral select is high, pad_out equals that pin's per_out bit, registered one clock edge later.
- R6: On a pin whose peripheral select is high, pad_oe equals that pin's per_oe bit (1 means drive), registered one clock edge later, regardless of the direction bit.
- R7: Peripheral takeover never changes the stored latches. Reading the direction register returns the stored bits, not the effective pad direction.
- R8: A change on pad_in shows on the pin read (rd_sel=2) and on per_in after exactly two rising edges, and not after one. The pin read never reflects the data latch.
- R9: When a pin's peripheral select drops, that pin returns to the stored direction and data values at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_sel | input | 1 | Write target: 0 data latch, 1 direction |
| wr_data | input | 8 | Write value |
| rd_sel | input | 2 | Read source: 0 data, 1 direction, 2 pins, 3 zero |
| rd_data | output | 8 | Read value |
| per_sel | input | 8 | Per-pin peripheral takeover select |
| per_out | input | 8 | Peripheral output values |
| per_oe | input | 8 | Peripheral output enables (1 = drive) |
| per_in | output | 8 | Synchronised pin levels to peripherals |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables (1 = drive) |

## Verification
A corrupted direction or data latch is visible at once on the read port, and on pad_oe or pad_out one edge later. The sweeps pair every latch pattern with a check of both paths. A fault in the takeover mux shows on the pad one edge after the select changes. The override sweep walks all 256 select patterns, so a swapped or stuck per-pin select cannot hide. A synchroniser with the wrong depth shows as pin-read data that arrives one edge early or late, and the bench checks both edges.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

    localparam int PORT_W = 8;

    typedef enum logic [1:0] {
        RD_LATCH = 2'd0,
        RD_DIR   = 2'd1,
        RD_PINS  = 2'd2,
        RD_ZERO  = 2'd3
    } rd_src_e;

    typedef enum logic {
        WR_LATCH = 1'b0,
        WR_DIR   = 1'b1
    } wr_tgt_e;

    typedef struct packed {
        logic val;
        logic oe;
    } pin_drv_t;

    // Per-pin drive selection: a peripheral owns both value and enable,
    // otherwise the stored latch value and inverted direction apply.
    function automatic pin_drv_t pick_drive(input logic sel, input logic pval,
                                            input logic poe, input logic lat,
                                            input logic dir);
        pin_drv_t d;
        if (sel) begin
            d.val = pval;
            d.oe  = poe;
        end else begin
            d.val = lat;
            d.oe  = ~dir;
        end
        return d;
    endfunction

endpackage

// File: rtl/port_regs.sv
module port_regs
    import gpio_ovr_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] lat_q,
    output logic [W-1:0] dir_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            dir_q <= '1;
        end else if (wr_en) begin
            if (wr_tgt_e'(wr_sel) == WR_DIR) dir_q <= wr_data;
            else                             lat_q <= wr_data;
        end
    end

    // R3 / R7: the direction register only changes through a direction write
    a_r7_dir_only_by_write: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel) |=> $stable(dir_q));

    // R3: the data latch only changes through a data write
    a_r3_lat_only_by_write: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && !wr_sel) |=> $stable(lat_q));

endmodule

// File: rtl/port_drive.sv
module port_drive
    import gpio_ovr_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lat_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] per_sel,
    input  logic [W-1:0] per_out,
    input  logic [W-1:0] per_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    pin_drv_t [W-1:0] nxt;
    pin_drv_t [W-1:0] cur;

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign nxt[i]     = pick_drive(per_sel[i], per_out[i], per_oe[i],
                                       lat_q[i], dir_q[i]);
        assign pad_out[i] = cur[i].val;
        assign pad_oe[i]  = cur[i].oe;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    // R2: an unselected input-direction pin never drives
    a_r2_input_hiz: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pad_oe & ~$past(per_sel) & $past(dir_q)) == '0));

    // R6: a selected pin with peripheral enable high always drives
    a_r6_periph_forces_out: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~pad_oe & $past(per_sel) & $past(per_oe)) == '0));

    // R5: a selected pin carries the peripheral value
    a_r5_periph_value: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pad_out ^ $past(per_out)) & $past(per_sel)) == '0));

endmodule

// File: rtl/port_sync.sv
module port_sync
    import gpio_ovr_pkg::*;
#(
    parameter int W      = PORT_W,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

    if (STAGES == 2) begin : g_chk
        // R8: pad level appears on the output exactly two edges later
        a_r8_two_edge_delay: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |=> (q == $past(d, 2)));
    end

endmodule

// File: rtl/pin_port_ovr.sv
module pin_port_ovr
    import gpio_ovr_pkg::*;
#(
    parameter int W           = PORT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] per_sel,
    input  logic [W-1:0] per_out,
    input  logic [W-1:0] per_oe,
    output logic [W-1:0] per_in,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    logic [W-1:0] lat_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pins_s;

    port_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .lat_q(lat_q), .dir_q(dir_q)
    );

    port_drive #(.W(W)) u_drive (
        .clk(clk), .rst(rst), .lat_q(lat_q), .dir_q(dir_q),
        .per_sel(per_sel), .per_out(per_out), .per_oe(per_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    port_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(pins_s)
    );

    assign per_in = pins_s;

    always_comb begin
        unique case (rd_src_e'(rd_sel))
            RD_LATCH: rd_data = lat_q;
            RD_DIR:   rd_data = dir_q;
            RD_PINS:  rd_data = pins_s;
            default:  rd_data = '0;
        endcase
    end

    // R4: the pin read and the peripheral input bus carry the same levels
    a_r4_pins_match_per_in: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 2'd2) |-> (rd_data == per_in));

    // R9: a pin released by its peripheral drives the stored configuration
    a_r9_release_restores: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pad_oe ^ ~$past(dir_q)) & ~$past(per_sel)) == '0));

endmodule

// File: tb/sim_pin_port_ovr.sv
module sim_pin_port_ovr;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic [7:0] per_sel = '0;
    logic [7:0] per_out = '0;
    logic [7:0] per_oe = '0;
    logic [7:0] per_in;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pin_port_ovr u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .per_sel(per_sel), .per_out(per_out),
        .per_oe(per_oe), .per_in(per_in), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        rd_sel = s;
        #1 v = rd_data;
    endtask

    // write applied at one negedge, captured at the next posedge
    task automatic wr(input logic tgt, input logic [7:0] v);
        wr_en = 1'b1; wr_sel = tgt; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] dv;
        logic [7:0] eo, ee;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd1, v); chk("R1 dir", v, 8'hFF);
        rd(2'd0, v); chk("R1 latch", v, 8'h00);
        rd(2'd2, v); chk("R1 pins", v, 8'h00);
        chk("R1 pad_oe", pad_oe, 8'h00);
        rd(2'd3, v); chk("R4 zero read", v, 8'h00);

        // R2 / R3 sweep of data and direction patterns
        for (int i = 0; i < 256; i++) begin
            dv = {i[3:0], i[7:4]} ^ 8'h5A;
            wr(1'b0, i[7:0]);
            wr(1'b1, dv);
            rd(2'd0, v); chk("R3 latch read", v, i[7:0]);
            rd(2'd1, v); chk("R3 dir read", v, dv);
            @(negedge clk);
            chk("R2 pad_oe", pad_oe, ~dv);
            chk("R2 pad_out", pad_out, i[7:0]);
        end

        // R3 no write when strobe low
        wr_sel = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        rd(2'd1, v); chk("R3 no strobe dir", v, {4'hF, 4'hF} ^ 8'h5A);

        // R5 / R6 / R7 override sweep
        wr(1'b0, 8'h3C);
        wr(1'b1, 8'hF0);
        for (int s = 0; s < 256; s++) begin
            per_sel = s[7:0];
            per_out = ~s[7:0];
            per_oe  = {s[0], s[7:1]} ^ 8'h33;
            @(negedge clk);
            eo = (per_sel & per_out) | (~per_sel & 8'h3C);
            ee = (per_sel & per_oe) | (~per_sel & ~8'hF0);
            chk("R5 pad_out override", pad_out, eo);
            chk("R6 pad_oe override", pad_oe, ee);
            rd(2'd1, v); chk("R7 dir stored", v, 8'hF0);
            rd(2'd0, v); chk("R7 latch stored", v, 8'h3C);
        end

        // R9 release returns at next edge
        per_sel = 8'hFF; per_oe = 8'hFF; per_out = 8'hA5;
        @(negedge clk);
        chk("R6 forced drive", pad_oe, 8'hFF);
        per_sel = 8'h00;
        @(negedge clk);
        chk("R9 release oe", pad_oe, 8'h0F);
        chk("R9 release out", pad_out, 8'h3C);

        // R8 synchroniser depth, several patterns
        for (int k = 0; k < 4; k++) begin
            v = 8'h11 << k;
            pad_in = v ^ 8'hC3;
            @(negedge clk);
            rd(2'd2, dv); chk("R8 not after one edge", dv, (k == 0) ? 8'h00 : ((8'h11 << (k - 1)) ^ 8'hC3));
            @(negedge clk);
            rd(2'd2, dv); chk("R8 pins after two", dv, v ^ 8'hC3);
            chk("R8 per_in", per_in, v ^ 8'hC3);
            rd(2'd0, dv); chk("R8 latch untouched", dv, 8'h3C);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule